// File: doc/BRIEF.md
# Shared-Port Fetch Stall Controller

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose instruction fetch and data access share one memory port. It tracks an occupancy bit for every stage and a memory-reference flag for the instructions in execute and memory. The decode stage reports through `dec_mem` whether its instruction is a load or a store, and that flag travels with the instruction.

When a valid load or store is in the memory stage, the data access takes the port and the fetch is held. The program counter keeps its value, and an empty slot enters decode behind the held fetch. The empty slot then moves down the pipeline like a real instruction. The stages after fetch are never frozen, so each memory reference costs exactly one fetch cycle.

Two counters are provided so that program timing can be checked: one counts cycles since reset and one counts stall cycles.

Top module: `uhz_ctrl`

## Requirements
- R1: While `rst` is high, `occ` is 0, `pc` is 0, `fetch_en` and `mem_req` are 0, and both counters read 0.
- R2: In the first cycle after reset is released, fetch is enabled at `pc` 0. Each cycle with `fetch_en` high advances `pc` by 4 at the next edge.
- R3: When the memory stage holds a valid load or store, `mem_sel_data` is 1 and `fetch_en` is 0 in that same cycle. In every other running cycle `mem_sel_data` is 0 and `fetch_en` is 1.
- R4: In a stall cycle `pc_hold` is 1 and `pc` keeps its value through the next edge.
- R5: Occupancy bits in `occ` are fetch=bit0, decode=bit1, execute=bit2, memory=bit3, writeback=bit4. A stall cycle has `bubble_ins` high, and the decode bit is 0 in the following cycle. That empty slot then appears in execute, memory and writeback on the next three cycles.
- R6: `dec_mem` has no effect while decode is empty. An empty slot never causes a stall.
- R7: Each load or store in a run of consecutive memory instructions causes its own single-cycle stall. A fetch at cycle c is held exactly when the instruction fetched at cycle c-3 is a memory reference.
- R8: `cyc_cnt` reads the number of cycles since reset was released. `stall_cnt` reads the number of stall cycles before the current cycle. A program of N instructions containing M memory references, where none of its last three instructions is a memory reference, retires its last instruction in writeback when `cyc_cnt` equals N+3+M.
- R9: `mem_req` is 1 in every cycle after reset is released, because the port serves either a fetch or a data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_mem | input | 1 | Instruction in decode is a load or store |
| mem_req | output | 1 | Shared memory port is requested |
| mem_sel_data | output | 1 | 1: port address from the data access, 0: from the PC |
| fetch_en | output | 1 | Fetch uses the port this cycle |
| pc_hold | output | 1 | PC is frozen this cycle |
| bubble_ins | output | 1 | An empty slot enters decode at the next edge |
| occ | output | 5 | Stage occupancy, fetch at bit 0 to writeback at bit 4 |
| pc | output | AW | Fetch address |
| cyc_cnt | output | CW | Cycles since reset release |
| stall_cnt | output | CW | Stall cycles counted so far |

## Verification
Three programs are run, with a reset between them. The first mixes isolated memory instructions with an adjacent pair, which shows that a single reference costs one cycle and that two back-to-back references each cost their own cycle. The second has three consecutive memory instructions; a design that merges stalls or freezes the later stages would retire it at a different cycle. The third has no memory references and must run stall-free. During every empty decode slot the bench holds `dec_mem` high, so a design that lets an empty slot request the port stalls where it should not.

// File: rtl/uhz_pkg.sv
package uhz_pkg;

    localparam int NSTAGE = 5;

    typedef enum logic [2:0] {
        ST_IF  = 3'd0,
        ST_ID  = 3'd1,
        ST_EX  = 3'd2,
        ST_MEM = 3'd3,
        ST_WB  = 3'd4
    } stage_e;

    typedef struct packed {
        logic wb;
        logic mem;
        logic ex;
        logic id;
        logic fe;
    } occ_t;

    function automatic logic port_to_data(input logic mem_valid, input logic mem_ref);
        return mem_valid & mem_ref;
    endfunction

endpackage

// File: rtl/uhz_fetch.sv
module uhz_fetch #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    output logic          fetch_en,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] pc_q;

    assign fetch_en = !rst && !hold;
    assign pc       = pc_q;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (fetch_en)
            pc_q <= pc_q + INC;
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        fetch_en |=> (pc == $past(pc) + INC)); // R2

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pc)); // R4

endmodule

// File: rtl/uhz_slots.sv
module uhz_slots #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             dec_mem,
    output logic [DEPTH-1:0] valid,
    output logic             mem_busy
);
    localparam int MEM_IX = DEPTH - 2;
    localparam int NREF   = MEM_IX;

    logic [DEPTH-1:0] v_q;
    logic [NREF-1:0]  m_q;

    always_ff @(posedge clk) begin
        if (rst)
            v_q[0] <= 1'b0;
        else
            v_q[0] <= enter;
    end

    genvar i;
    generate
        for (i = 1; i < DEPTH; i++) begin : g_v
            always_ff @(posedge clk) begin
                if (rst)
                    v_q[i] <= 1'b0;
                else
                    v_q[i] <= v_q[i-1];
            end
        end

        for (i = 0; i < NREF; i++) begin : g_m
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)
                        m_q[i] <= 1'b0;
                    else
                        m_q[i] <= v_q[0] & dec_mem;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst)
                        m_q[i] <= 1'b0;
                    else
                        m_q[i] <= m_q[i-1];
                end
            end
        end
    endgenerate

    assign valid    = v_q;
    assign mem_busy = uhz_pkg::port_to_data(v_q[MEM_IX], m_q[NREF-1]);

    AST_EMPTY_NO_REF: assert property (@(posedge clk) disable iff (rst)
        !v_q[0] |=> !m_q[0]); // R6

    generate
        for (i = 1; i < DEPTH; i++) begin : g_chk
            AST_BUBBLE_MOVES: assert property (@(posedge clk) disable iff (rst)
                !v_q[i-1] |=> !v_q[i]); // R5
        end
    endgenerate

endmodule

// File: rtl/uhz_perf.sv
module uhz_perf #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall,
    output logic [CW-1:0] cyc_cnt,
    output logic [CW-1:0] stall_cnt
);
    logic [CW-1:0] cyc_q, stl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            stl_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (stall)
                stl_q <= stl_q + 1'b1;
        end
    end

    assign cyc_cnt   = cyc_q;
    assign stall_cnt = stl_q;

    AST_STALL_LE_CYC: assert property (@(posedge clk) disable iff (rst)
        stl_q <= cyc_q); // R8

endmodule

// File: rtl/uhz_ctrl.sv
module uhz_ctrl #(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_mem,
    output logic          mem_req,
    output logic          mem_sel_data,
    output logic          fetch_en,
    output logic          pc_hold,
    output logic          bubble_ins,
    output logic [4:0]    occ,
    output logic [AW-1:0] pc,
    output logic [CW-1:0] cyc_cnt,
    output logic [CW-1:0] stall_cnt
);
    import uhz_pkg::*;

    localparam int DEPTH = NSTAGE - 1;

    logic             data_wins;
    logic             fe;
    logic [DEPTH-1:0] later_v;
    occ_t             occ_s;

    uhz_fetch #(.AW(AW), .STEP(STEP)) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .hold     (data_wins),
        .fetch_en (fe),
        .pc       (pc)
    );

    uhz_slots #(.DEPTH(DEPTH)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .enter    (fe),
        .dec_mem  (dec_mem),
        .valid    (later_v),
        .mem_busy (data_wins)
    );

    uhz_perf #(.CW(CW)) u_perf (
        .clk       (clk),
        .rst       (rst),
        .stall     (data_wins),
        .cyc_cnt   (cyc_cnt),
        .stall_cnt (stall_cnt)
    );

    always_comb begin
        occ_s.fe  = fe;
        occ_s.id  = later_v[ST_ID  - 1];
        occ_s.ex  = later_v[ST_EX  - 1];
        occ_s.mem = later_v[ST_MEM - 1];
        occ_s.wb  = later_v[ST_WB  - 1];
    end

    assign occ          = occ_s;
    assign fetch_en     = fe;
    assign mem_sel_data = data_wins;
    assign pc_hold      = data_wins;
    assign bubble_ins   = data_wins;
    assign mem_req      = fe | data_wins;

    AST_DATA_OWNS_PORT: assert property (@(posedge clk) disable iff (rst)
        mem_sel_data |-> !fetch_en); // R3

    AST_PORT_ALWAYS_USED: assert property (@(posedge clk) disable iff (rst)
        mem_req); // R9

    AST_BUBBLE_IN_ID: assert property (@(posedge clk) disable iff (rst)
        bubble_ins |=> !occ[1]); // R5

    AST_ONE_SLOT_LOST: assert property (@(posedge clk) disable iff (rst)
        mem_sel_data |=> (pc == $past(pc))); // R4

endmodule

// File: tb/uhz_ctrl_test.sv
module uhz_ctrl_test;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int MAXC = 64;

    typedef struct {
        int  cyc;
        logic fe;
        logic sel;
        logic [4:0] occ;
        logic [AW-1:0] pc;
        int  stalls;
        logic last_wb;
        int  total;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_mem = 1'b0;
    logic mem_req, mem_sel_data, fetch_en, pc_hold, bubble_ins;
    logic [4:0] occ;
    logic [AW-1:0] pc;
    logic [CW-1:0] cyc_cnt, stall_cnt;

    int checks = 0;
    int fails = 0;
    bit mon_on = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    uhz_ctrl #(.AW(AW), .CW(CW), .STEP(4)) uut (
        .clk(clk), .rst(rst), .dec_mem(dec_mem),
        .mem_req(mem_req), .mem_sel_data(mem_sel_data), .fetch_en(fetch_en),
        .pc_hold(pc_hold), .bubble_ins(bubble_ins), .occ(occ), .pc(pc),
        .cyc_cnt(cyc_cnt), .stall_cnt(stall_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(fetch_en == e.fe, "R3", $sformatf("fetch_en c%0d", e.cyc), fetch_en, e.fe);
            chk(mem_sel_data == e.sel, "R3", $sformatf("mem_sel_data c%0d", e.cyc), mem_sel_data, e.sel);
            chk(pc_hold == e.sel && bubble_ins == e.sel, "R4", $sformatf("hold/bubble c%0d", e.cyc),
                {pc_hold, bubble_ins}, {e.sel, e.sel});
            chk(pc == e.pc, "R2", $sformatf("pc c%0d", e.cyc), pc, e.pc);
            chk(occ == e.occ, "R5", $sformatf("occ c%0d", e.cyc), occ, e.occ);
            chk(mem_req == 1'b1, "R9", $sformatf("mem_req c%0d", e.cyc), mem_req, 1);
            chk(cyc_cnt == CW'(e.cyc), "R8", $sformatf("cyc_cnt c%0d", e.cyc), cyc_cnt, e.cyc);
            chk(stall_cnt == CW'(e.stalls), "R7", $sformatf("stall_cnt c%0d", e.cyc), stall_cnt, e.stalls);
            if (e.last_wb) begin
                chk(occ[4] && int'(cyc_cnt) + 1 == e.total, "R8", "cycles to retire program",
                    int'(cyc_cnt) + 1, e.total);
            end
        end
    end

    // prog bit k set: instruction k is a load or store
    task automatic run_prog(input logic [31:0] prog, input int n);
        bit fetched [MAXC];
        int idx [MAXC];
        bit stall [MAXC];
        bit drv [MAXC];
        int nfetch, nst, m, total, ncyc, last_wb;
        m = 0;
        for (int k = 0; k < n; k++) if (prog[k]) m++;
        total = n + 4 + m;
        ncyc = total + 2;
        nfetch = 0;
        // schedule from the requirements: fetch at c held when fetch at c-3 was a memory op
        for (int c = 0; c < ncyc; c++) begin
            stall[c] = (c >= 3) && fetched[c-3] && idx[c-3] < n && prog[idx[c-3]];
            fetched[c] = !stall[c];
            idx[c] = nfetch;
            if (fetched[c]) nfetch++;
            if (c == 0 || !fetched[c-1]) drv[c] = 1'b1; // R6: empty decode sees dec_mem=1
            else drv[c] = (idx[c-1] < n) ? prog[idx[c-1]] : 1'b0;
        end
        last_wb = -1;
        for (int c = 4; c < ncyc; c++)
            if (fetched[c-4] && idx[c-4] == n - 1) last_wb = c;
        nst = 0;
        for (int c = 0; c < ncyc; c++) begin
            exp_t e;
            e.cyc = c;
            e.fe = !stall[c];
            e.sel = stall[c];
            e.occ[0] = fetched[c];
            for (int s = 1; s < 5; s++) e.occ[s] = (c >= s) ? fetched[c-s] : 1'b0;
            e.pc = AW'(4 * idx[c]);
            e.stalls = nst;
            e.last_wb = (c == last_wb);
            e.total = total;
            q.push_back(e);
            if (stall[c]) nst++;
        end

        // reset phase
        @(posedge clk); #1 rst = 1'b1; dec_mem = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk(occ == 5'b0, "R1", "occ in reset", occ, 0);
        chk(pc == '0 && !fetch_en && !mem_req, "R1", "pc/fetch/req in reset",
            {pc[3:0], fetch_en, mem_req}, 0);
        chk(cyc_cnt == '0 && stall_cnt == '0, "R1", "counters in reset",
            cyc_cnt + stall_cnt, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        mon_on = 1;
        for (int c = 0; c < ncyc; c++) begin
            dec_mem = drv[c];
            @(posedge clk); #1;
        end
        mon_on = 0;
        chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
        q.delete();
    endtask

    initial begin
        // mems at 0, 3, 4 (adjacent pair), 6; last three plain
        run_prog(32'b00_0101_1001, 10);
        // three consecutive mems at 1..3
        run_prog(32'b0000_1110, 8);
        // no mems
        run_prog(32'b0, 6);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule